// File: doc/BRIEF.md
# Double-Buffered Input Gamma Lookup

This block applies an input gamma curve to a stream of RGB pixels. Each colour channel has its own 256-entry table of 12-bit unsigned fractions. Two complete sets of tables, bank A and bank B, let software fill one bank while the pixel path reads the other. When the new curve is ready, software selects it. The switch takes effect at the next frame-start pulse, so no frame is rendered with a mix of two curves.

Software loads a table through a small host port with address, data and write/read strobes. It first sets a starting index. It then writes colour values one after another to a single data register. The block steers these writes to red, then green, then blue, and then moves on to the next index. A per-channel mask lets a load touch only some channels. A power bit must be set for any table write to land. A read-only status register reports which bank, if any, drives the pixel path.

The pixel side accepts an input colour wider than 8 bits and keeps its top 8 bits as the table index. It returns the 12-bit result one cycle later, with the valid flag delayed by the same amount.

Top module: `igam_lut_stage`

## Requirements
- R1: After reset, `pix_vld_o` is low, the status register reads 0, and the control register (address 0) reads 0x07.
- R2: The lookup index for each channel is the 8 most significant bits of the `IN_W`-bit input colour.
- R3: When the active mode is neither 2 nor 3, each output channel equals its 8-bit index placed in bits 11:4, with bits 3:0 zero.
- R4: The mode field is control bits 6:5. Active mode 2 returns the bank A entry for the index, and active mode 3 returns the bank B entry.
- R5: A new mode value only becomes active on a cycle where `frame_start_i` is high. Pixels presented in the cycles after that pulse use the new mode, and earlier pixels use the old one.
- R6: Status register (address 3, bits 1:0) reads 1 when bank A is active, 2 when bank B is active, and 0 in bypass. Writes to it have no effect.
- R7: Every valid input pixel produces exactly one valid output pixel one clock later. No output is valid without a matching input.
- R8: A write to address 1 sets the load index from data bits 7:0. Each write to address 2 stores data bits 11:0 into the current channel in the order red, green, blue. After blue, the index advances by one and wraps from 255 to 0. Reading address 1 returns the current index.
- R9: A write to address 1 also returns the channel sequence to red.
- R10: Control bits 2:0 enable stores for red (bit 0), green (bit 1) and blue (bit 2). A disabled channel still takes its turn in the sequence, and its entry stays unchanged.
- R11: Control bit 4 is the table power bit. While it is 0, writes to address 2 store nothing and do not move the index or the channel sequence.
- R12: Control bit 3 selects the bank that loads land in (0 = A, 1 = B). Loading the inactive bank does not change the results returned for the active bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hst_wr | input | 1 | Host write strobe |
| hst_rd | input | 1 | Host read strobe; data appears on `hst_rdata` the next cycle |
| hst_addr | input | ADDR_W | Host register address |
| hst_wdata | input | DATA_W | Host write data |
| hst_rdata | output | DATA_W | Host read data |
| frame_start_i | input | 1 | Frame-start pulse that commits the mode field |
| pix_vld_i | input | 1 | Input pixel valid |
| pix_r_i | input | IN_W | Input red |
| pix_g_i | input | IN_W | Input green |
| pix_b_i | input | IN_W | Input blue |
| pix_vld_o | output | 1 | Output pixel valid |
| pix_r_o | output | 12 | Red result, u0.12 |
| pix_g_o | output | 12 | Green result, u0.12 |
| pix_b_o | output | 12 | Blue result, u0.12 |

## Verification
The hardest situation to reach is the one the banking exists for. Software fills the idle bank while pixels keep reading the active bank, and then a mode write sits pending until the frame pulse. The stimulus loads all of bank B with pixels interleaved between the sequential writes, and checks every one of those pixels against bank A. It then writes the new mode and sends a pixel before the frame pulse to show the old bank still drives the output. Only after the pulse does it expect bank B results.

// File: rtl/igam_pkg.sv
package igam_pkg;

    localparam int IDX_W   = 8;
    localparam int ENTRIES = 1 << IDX_W;
    localparam int FRAC_W  = 12;
    localparam int NCH     = 3;
    localparam int NBANK   = 2;

    localparam int REG_CTRL   = 0;
    localparam int REG_INDEX  = 1;
    localparam int REG_SEQ    = 2;
    localparam int REG_STATUS = 3;

    localparam logic [1:0] MODE_BANK_A = 2'd2;
    localparam logic [1:0] MODE_BANK_B = 2'd3;

    localparam logic [1:0] STAT_BYPASS = 2'd0;
    localparam logic [1:0] STAT_A      = 2'd1;
    localparam logic [1:0] STAT_B      = 2'd2;

    typedef enum logic [1:0] {
        PH_R = 2'd0,
        PH_G = 2'd1,
        PH_B = 2'd2
    } seq_phase_e;

    // control register layout, MSB first: mode[6:5] pwr[4] bank[3] mask[2:0]
    typedef struct packed {
        logic [1:0] mode;
        logic       mem_pwr;
        logic       wr_bank;
        logic [2:0] wen_mask;
    } ctrl_t;

    localparam ctrl_t CTRL_RST = '{mode: 2'd0, mem_pwr: 1'b0, wr_bank: 1'b0, wen_mask: 3'b111};

    function automatic logic [1:0] status_code(input logic [1:0] mode);
        case (mode)
            MODE_BANK_A: return STAT_A;
            MODE_BANK_B: return STAT_B;
            default:     return STAT_BYPASS;
        endcase
    endfunction

endpackage

// File: rtl/igam_chan_ram.sv
module igam_chan_ram #(
    parameter int DEPTH = 256,
    parameter int DW    = 12
) (
    input  logic                     clk,
    input  logic                     we,
    input  logic [$clog2(DEPTH)-1:0] waddr,
    input  logic [DW-1:0]            wdata,
    input  logic [$clog2(DEPTH)-1:0] raddr,
    output logic [DW-1:0]            rdata
);
    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
        rdata <= mem[raddr];
    end
endmodule

// File: rtl/igam_host_regs.sv
module igam_host_regs
    import igam_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hst_wr,
    input  logic              hst_rd,
    input  logic [ADDR_W-1:0] hst_addr,
    input  logic [DATA_W-1:0] hst_wdata,
    input  logic [1:0]        active_code,
    output logic [DATA_W-1:0] hst_rdata,
    output ctrl_t             ctrl_q,
    output logic [NCH-1:0]    tbl_we,
    output logic              tbl_bank,
    output logic [IDX_W-1:0]  tbl_idx,
    output logic [FRAC_W-1:0] tbl_data
);
    localparam int CTRL_W = $bits(ctrl_t);

    seq_phase_e       phase_q;
    logic [IDX_W-1:0] idx_q;
    logic             wr_ctrl, wr_idx, wr_seq, seq_go;

    assign wr_ctrl = hst_wr && (hst_addr == ADDR_W'(REG_CTRL));
    assign wr_idx  = hst_wr && (hst_addr == ADDR_W'(REG_INDEX));
    assign wr_seq  = hst_wr && (hst_addr == ADDR_W'(REG_SEQ));
    assign seq_go  = wr_seq && ctrl_q.mem_pwr;

    always_comb begin
        tbl_we = '0;
        if (seq_go) begin
            tbl_we[phase_q] = ctrl_q.wen_mask[phase_q];
        end
    end

    assign tbl_bank = ctrl_q.wr_bank;
    assign tbl_idx  = idx_q;
    assign tbl_data = hst_wdata[FRAC_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q  <= CTRL_RST;
            phase_q <= PH_R;
            idx_q   <= '0;
        end else begin
            if (wr_ctrl) begin
                ctrl_q <= ctrl_t'(hst_wdata[CTRL_W-1:0]);
            end
            if (wr_idx) begin
                idx_q   <= hst_wdata[IDX_W-1:0];
                phase_q <= PH_R;
            end else if (seq_go) begin
                if (phase_q == PH_B) begin
                    phase_q <= PH_R;
                    idx_q   <= idx_q + 1'b1;
                end else begin
                    phase_q <= seq_phase_e'(phase_q + 2'd1);
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hst_rdata <= '0;
        end else if (hst_rd) begin
            hst_rdata <= '0;
            case (int'(hst_addr))
                REG_CTRL:   hst_rdata <= DATA_W'(ctrl_q);
                REG_INDEX:  hst_rdata <= DATA_W'(idx_q);
                REG_STATUS: hst_rdata <= DATA_W'(active_code);
                default:    hst_rdata <= '0;
            endcase
        end
    end
endmodule

// File: rtl/igam_lut_stage.sv
module igam_lut_stage
    import igam_pkg::*;
#(
    parameter int IN_W   = 10,
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hst_wr,
    input  logic              hst_rd,
    input  logic [ADDR_W-1:0] hst_addr,
    input  logic [DATA_W-1:0] hst_wdata,
    output logic [DATA_W-1:0] hst_rdata,
    input  logic              frame_start_i,
    input  logic              pix_vld_i,
    input  logic [IN_W-1:0]   pix_r_i,
    input  logic [IN_W-1:0]   pix_g_i,
    input  logic [IN_W-1:0]   pix_b_i,
    output logic              pix_vld_o,
    output logic [11:0]       pix_r_o,
    output logic [11:0]       pix_g_o,
    output logic [11:0]       pix_b_o
);
    localparam int PAD_W = FRAC_W - IDX_W;

    ctrl_t             ctrl_q;
    logic [NCH-1:0]    tbl_we;
    logic              tbl_bank;
    logic [IDX_W-1:0]  tbl_idx;
    logic [FRAC_W-1:0] tbl_data;
    logic [1:0]        act_mode_q;
    logic [1:0]        active_code;

    logic [IN_W-1:0]   pix_in    [NCH];
    logic [IDX_W-1:0]  pix_idx   [NCH];
    logic [FRAC_W-1:0] rd_data   [NBANK][NCH];
    logic [IDX_W-1:0]  byp_idx_q [NCH];
    logic [FRAC_W-1:0] out_frac  [NCH];
    logic              vld_q, byp_q, bsel_q;

    igam_host_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .hst_wr     (hst_wr),
        .hst_rd     (hst_rd),
        .hst_addr   (hst_addr),
        .hst_wdata  (hst_wdata),
        .active_code(active_code),
        .hst_rdata  (hst_rdata),
        .ctrl_q     (ctrl_q),
        .tbl_we     (tbl_we),
        .tbl_bank   (tbl_bank),
        .tbl_idx    (tbl_idx),
        .tbl_data   (tbl_data)
    );

    // mode commits only on a frame boundary
    always_ff @(posedge clk) begin
        if (rst) begin
            act_mode_q <= 2'd0;
        end else if (frame_start_i) begin
            act_mode_q <= ctrl_q.mode;
        end
    end

    assign active_code = status_code(act_mode_q);

    assign pix_in[0] = pix_r_i;
    assign pix_in[1] = pix_g_i;
    assign pix_in[2] = pix_b_i;

    for (genvar c = 0; c < NCH; c++) begin : g_idx
        if (IN_W >= IDX_W) begin : g_trunc
            assign pix_idx[c] = pix_in[c][IN_W-1 -: IDX_W];
        end else begin : g_widen
            assign pix_idx[c] = {pix_in[c], {(IDX_W-IN_W){1'b0}}};
        end
    end

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        for (genvar c = 0; c < NCH; c++) begin : g_ch
            igam_chan_ram #(.DEPTH(ENTRIES), .DW(FRAC_W)) u_ram (
                .clk  (clk),
                .we   (tbl_we[c] && (tbl_bank == 1'(b))),
                .waddr(tbl_idx),
                .wdata(tbl_data),
                .raddr(pix_idx[c]),
                .rdata(rd_data[b][c])
            );
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q  <= 1'b0;
            byp_q  <= 1'b1;
            bsel_q <= 1'b0;
            for (int c = 0; c < NCH; c++) byp_idx_q[c] <= '0;
        end else begin
            vld_q  <= pix_vld_i;
            byp_q  <= (active_code == STAT_BYPASS);
            bsel_q <= (active_code == STAT_B);
            for (int c = 0; c < NCH; c++) byp_idx_q[c] <= pix_idx[c];
        end
    end

    always_comb begin
        for (int c = 0; c < NCH; c++) begin
            out_frac[c] = byp_q ? {byp_idx_q[c], {PAD_W{1'b0}}} : rd_data[bsel_q][c];
        end
    end

    assign pix_vld_o = vld_q;
    assign pix_r_o   = out_frac[0];
    assign pix_g_o   = out_frac[1];
    assign pix_b_o   = out_frac[2];
endmodule

// File: rtl/igam_lut_stage_chk.sv
module igam_lut_stage_chk #(
    parameter int ADDR_W = 4,
    parameter int FRAC_W = 12
) (
    input logic              clk,
    input logic              rst,
    input logic              hst_wr,
    input logic [ADDR_W-1:0] hst_addr,
    input logic              frame_start_i,
    input logic              pix_vld_i,
    input logic              pix_vld_o,
    input logic [FRAC_W-1:0] pix_r_o,
    input logic [FRAC_W-1:0] pix_g_o,
    input logic [FRAC_W-1:0] pix_b_o,
    input logic [1:0]        active_code,
    input logic [2:0]        tbl_we,
    input logic              mem_pwr
);
    // R7
    vld_follow_chk: assert property (@(posedge clk) disable iff (rst)
        pix_vld_i |=> pix_vld_o);

    // R7
    no_spurious_vld_chk: assert property (@(posedge clk) disable iff (rst)
        !pix_vld_i |=> !pix_vld_o);

    // R5
    mode_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !frame_start_i |=> $stable(active_code));

    // R6
    status_legal_chk: assert property (@(posedge clk) disable iff (rst)
        active_code != 2'd3);

    // R11
    pwr_gate_chk: assert property (@(posedge clk) disable iff (rst)
        !mem_pwr |-> tbl_we == 3'b000);

    // R9
    phase_restart_chk: assert property (@(posedge clk) disable iff (rst)
        (hst_wr && hst_addr == ADDR_W'(1)) |=> !(tbl_we[1] || tbl_we[2]));

    // R10
    one_channel_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(tbl_we));

    // R3
    bypass_pad_chk: assert property (@(posedge clk) disable iff (rst)
        (pix_vld_i && active_code == 2'd0) |=>
            (pix_r_o[3:0] == 4'd0 && pix_g_o[3:0] == 4'd0 && pix_b_o[3:0] == 4'd0));
endmodule

bind igam_lut_stage igam_lut_stage_chk #(.ADDR_W(ADDR_W), .FRAC_W(igam_pkg::FRAC_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .hst_wr       (hst_wr),
    .hst_addr     (hst_addr),
    .frame_start_i(frame_start_i),
    .pix_vld_i    (pix_vld_i),
    .pix_vld_o    (pix_vld_o),
    .pix_r_o      (pix_r_o),
    .pix_g_o      (pix_g_o),
    .pix_b_o      (pix_b_o),
    .active_code  (active_code),
    .tbl_we       (tbl_we),
    .mem_pwr      (ctrl_q.mem_pwr)
);

// File: tb/test_igam_lut_stage.sv
module test_igam_lut_stage;
    localparam int IN_W   = 10;
    localparam int ADDR_W = 4;
    localparam int DATA_W = 32;
    localparam int SH     = IN_W - 8;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic              rst = 1'b1;
    logic              hst_wr = 1'b0, hst_rd = 1'b0;
    logic [ADDR_W-1:0] hst_addr = '0;
    logic [DATA_W-1:0] hst_wdata = '0;
    logic [DATA_W-1:0] hst_rdata;
    logic              frame_start_i = 1'b0;
    logic              pix_vld_i = 1'b0;
    logic [IN_W-1:0]   pix_r_i = '0, pix_g_i = '0, pix_b_i = '0;
    logic              pix_vld_o;
    logic [11:0]       pix_r_o, pix_g_o, pix_b_o;

    igam_lut_stage #(.IN_W(IN_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_igam_lut_stage (
        .clk(clk), .rst(rst), .hst_wr(hst_wr), .hst_rd(hst_rd), .hst_addr(hst_addr),
        .hst_wdata(hst_wdata), .hst_rdata(hst_rdata), .frame_start_i(frame_start_i),
        .pix_vld_i(pix_vld_i), .pix_r_i(pix_r_i), .pix_g_i(pix_g_i), .pix_b_i(pix_b_i),
        .pix_vld_o(pix_vld_o), .pix_r_o(pix_r_o), .pix_g_o(pix_g_o), .pix_b_o(pix_b_o)
    );

    int n_chk = 0, n_fail = 0;

    // reference model
    int exp_tbl [2][3][256];
    int m_idx = 0, m_phase = 0, m_bank = 0, m_pwr = 0;
    int m_mask = 7, m_mode_req = 0, m_mode_act = 0;

    typedef struct {
        int r; int g; int b; string req;
    } exp_pix_t;
    exp_pix_t sb_q[$];

    task automatic check(string req, int act, int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic int tval(int i, int c, int b);
        return (i * 16 + c * 5 + b * 1365 + 3) & 12'hFFF;
    endfunction

    task automatic host_wr(int a, int d);
        @(negedge clk);
        hst_wr = 1'b1; hst_addr = ADDR_W'(a); hst_wdata = DATA_W'(d);
        case (a)
            0: begin
                m_mask = d & 7; m_bank = (d >> 3) & 1;
                m_pwr = (d >> 4) & 1; m_mode_req = (d >> 5) & 3;
            end
            1: begin m_idx = d & 255; m_phase = 0; end
            2: if (m_pwr != 0) begin
                if (((m_mask >> m_phase) & 1) != 0) exp_tbl[m_bank][m_phase][m_idx] = d & 12'hFFF;
                if (m_phase == 2) begin m_phase = 0; m_idx = (m_idx + 1) % 256; end
                else m_phase++;
            end
            default: ;
        endcase
        @(negedge clk);
        hst_wr = 1'b0;
    endtask

    task automatic host_rd(int a, output int v);
        @(negedge clk);
        hst_rd = 1'b1; hst_addr = ADDR_W'(a);
        @(negedge clk);
        hst_rd = 1'b0;
        v = int'(hst_rdata);
    endtask

    task automatic frame();
        @(negedge clk);
        frame_start_i = 1'b1;
        @(negedge clk);
        frame_start_i = 1'b0;
        m_mode_act = m_mode_req;
    endtask

    function automatic int model_out(int c, int x);
        int ix;
        ix = (x >> SH) & 255;
        if (m_mode_act == 2) return exp_tbl[0][c][ix];
        if (m_mode_act == 3) return exp_tbl[1][c][ix];
        return ix << 4;
    endfunction

    // driver: leaves valid high so bursts are contiguous
    task automatic send_pix(int r, int g, int b, string req);
        exp_pix_t e;
        @(negedge clk);
        pix_vld_i = 1'b1;
        pix_r_i = IN_W'(r); pix_g_i = IN_W'(g); pix_b_i = IN_W'(b);
        e.r = model_out(0, r); e.g = model_out(1, g); e.b = model_out(2, b); e.req = req;
        sb_q.push_back(e);
    endtask

    task automatic pix_idle();
        @(negedge clk);
        pix_vld_i = 1'b0;
    endtask

    // monitor
    always @(negedge clk) begin
        if (!rst && pix_vld_o) begin
            if (sb_q.size() == 0) begin
                check("R7 unexpected valid", 1, 0);
            end else begin
                exp_pix_t e;
                e = sb_q.pop_front();
                check(e.req, int'(pix_r_o), e.r);
                check(e.req, int'(pix_g_o), e.g);
                check(e.req, int'(pix_b_o), e.b);
            end
        end
    end

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        int v;
        for (int b = 0; b < 2; b++)
            for (int c = 0; c < 3; c++)
                for (int i = 0; i < 256; i++) exp_tbl[b][c][i] = 0;

        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1 vld", int'(pix_vld_o), 0);
        host_rd(0, v); check("R1 ctrl", v, 7);
        host_rd(3, v); check("R6 status reset", v, 0);

        // R3 bypass, R2 truncation of a 10-bit input
        send_pix(10'h3FF, 10'h000, 10'h2A5, "R3 R2 bypass");
        send_pix(10'h103, 10'h0FE, 10'h201, "R2 trunc");
        pix_idle();

        // load bank A with power on, mask all
        host_wr(0, 7 | 16);
        host_wr(1, 0);
        for (int i = 0; i < 256; i++)
            for (int c = 0; c < 3; c++) host_wr(2, tval(i, c, 0));
        host_rd(1, v); check("R8 index wrap after full load", v, 0);

        // R5 mode pending until frame start
        host_wr(0, 7 | 16 | (2 << 5));
        host_rd(3, v); check("R5 status before frame", v, 0);
        send_pix(12 << SH, 40 << SH, 200 << SH, "R5 old mode before frame");
        pix_idle();
        frame();
        host_rd(3, v); check("R6 status bank A", v, 1);
        for (int k = 0; k < 8; k++)
            send_pix(((k * 37) << SH) | 3, ((k * 53 + 9) & 255) << SH, ((255 - k * 31) & 255) << SH, "R4 R7 bank A burst");
        pix_idle();

        // R12 load bank B while bank A drives pixels
        host_wr(0, 7 | 16 | 8 | (2 << 5));
        host_wr(1, 0);
        for (int i = 0; i < 256; i++) begin
            for (int c = 0; c < 3; c++) host_wr(2, tval(i, c, 1));
            if ((i % 32) == 5) begin
                send_pix(i << SH, ((i + 1) & 255) << SH, ((i + 2) & 255) << SH, "R12 active bank undisturbed");
                pix_idle();
            end
        end
        host_wr(0, 7 | 16 | 8 | (3 << 5));
        send_pix(77 << SH, 78 << SH, 79 << SH, "R5 bank A until frame");
        pix_idle();
        frame();
        host_rd(3, v); check("R6 status bank B", v, 2);
        for (int k = 0; k < 6; k++)
            send_pix((k * 41) << SH, (k * 43 + 1) << SH, (k * 47 + 2) << SH, "R4 R7 bank B burst");
        pix_idle();

        // R10 mask: green only at index 5 of active bank B
        host_wr(0, 2 | 16 | 8 | (3 << 5));
        host_wr(1, 5);
        host_wr(2, 12'hABC); host_wr(2, 12'hABC); host_wr(2, 12'hABC);
        host_rd(1, v); check("R10 masked slots still advance", v, 6);
        send_pix(5 << SH, 5 << SH, 5 << SH, "R10 masked channels kept");
        pix_idle();
        check("R10 model green", exp_tbl[1][1][5], 12'hABC);

        // R9 index write restarts at red
        host_wr(0, 7 | 16 | 8 | (3 << 5));
        host_wr(1, 10);
        host_wr(2, 12'h111);
        host_wr(1, 10);
        host_wr(2, 12'h222);
        host_rd(1, v); check("R9 index unchanged mid entry", v, 10);
        send_pix(10 << SH, 10 << SH, 10 << SH, "R9 red rewritten green kept");
        pix_idle();

        // R8 wrap from 255
        host_wr(1, 255);
        host_wr(2, 1); host_wr(2, 2); host_wr(2, 3);
        host_rd(1, v); check("R8 wrap 255 to 0", v, 0);
        send_pix(255 << SH, 255 << SH, 255 << SH, "R8 entry 255 loaded");
        pix_idle();

        // R11 power off ignores sequential writes
        host_wr(0, 7 | 8 | (3 << 5));
        host_wr(1, 20);
        host_wr(2, 12'hFFF); host_wr(2, 12'hFFF); host_wr(2, 12'hFFF);
        host_rd(1, v); check("R11 index not advanced", v, 20);
        send_pix(20 << SH, 20 << SH, 20 << SH, "R11 table unchanged");
        pix_idle();

        // R6 writes to status have no effect; R3 bypass via mode 1
        host_wr(3, 3);
        host_rd(3, v); check("R6 status write ignored", v, 2);
        host_wr(0, 7 | (1 << 5));
        frame();
        host_rd(3, v); check("R6 status bypass", v, 0);
        send_pix(10'h155, 10'h2AA, 10'h0FF, "R3 bypass mode 1");
        pix_idle();

        repeat (4) @(negedge clk);
        check("R7 all outputs seen", sb_q.size(), 0);
        finish_run();
    end
endmodule